// File: doc/BRIEF.md
# Sticky NMI Flag Controller

This block gathers single-cycle error strobes from six hardware sources and holds each one in a sticky cause flag. The six sources are a stuck handshake, two self-test failures, an uncorrectable flash error, an uncorrectable RAM error and a clock failure. Next to the cause flags it keeps an interrupt flag, which marks that a non-maskable interrupt was raised. It also emits a one-clock NMI pulse each time that flag goes from 0 to 1.

A shadow register mirrors the flag register, so a second reader can see the same state. Software reads both through a small register bus. It clears bits by writing ones to a write-one-to-clear register.

While the interrupt flag is set, no further pulse is produced. The expected service order is to clear the causes first and the interrupt flag last. If a cause is still pending once the interrupt flag is cleared, the block raises the interrupt again. When a hardware set and a software clear hit the same bit in the same cycle, the set wins.

Top module: `sticky_nmi_ctrl`

## Requirements
- R1: After reset, the flag register, the shadow register and the NMI pulse are all 0.
- R2: A strobe on `cause_strb[i]` sets flag bit i+1 and shadow bit i+1 at the next clock edge. The cause bits are laid out as follows: bit 1 is clock fail, bit 2 is RAM uncorrectable, bit 3 is flash uncorrectable, bit 4 and bit 5 are the two self-test failures, and bit 6 is the handshake-stuck error.
- R3: A set cause flag stays set until it is cleared. Writing 0 to a bit of the clear register (address 2) has no effect, and writes to the flag register (address 0) or to the shadow register (address 1) change nothing.
- R4: Writing 1 to bit n of the clear register clears bit n in both the flag and the shadow register at that clock edge. The shadow register always equals the flag register.
- R5: When a strobe and a clear of the same bit land in the same cycle, the bit is set after the edge.
- R6: Bit 0 (the interrupt flag) is set at the edge where it is 0 and a cause flag is set or a strobe is arriving. `nmi_pulse` is high for exactly the one cycle that follows that edge.
- R7: While the interrupt flag stays set, new strobes produce no NMI pulse.
- R8: If the interrupt flag is cleared while a cause flag remains set, the interrupt flag is set again with a new pulse at the next edge. If no cause remains, no pulse follows.
- R9: `bus_rdata` shows the flag register for address 0 and the shadow register for address 1. It reads 0 for address 2 (the clear register) and for address 3. Bits 15 to 7 of the flag and shadow registers read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cause_strb | input | 6 | Single-cycle error strobes, index i sets flag bit i+1 |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 flag, 1 shadow, 2 clear |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| flag_q | output | 16 | Flag register contents |
| shadow_q | output | 16 | Shadow flag register contents |
| nmi_pulse | output | 1 | One-cycle NMI pulse |

## Verification
Strobes and clear writes take effect at the first clock edge that samples them. So flag, shadow and pulse values are due one edge after the stimulus, and `bus_rdata` follows the present address combinationally. The one exception is re-arming: a pending cause produces its new interrupt flag and pulse one edge after the edge that cleared the old interrupt flag, which is two edges after the clear write was driven. The bench drives inputs on the falling edge. It advances its model by one step per rising edge and compares every output at the next falling edge, so each result is checked in the cycle it becomes due.

// File: rtl/sticky_nmi_pkg.sv
package sticky_nmi_pkg;
  localparam int REG_W_DEF   = 16;
  localparam int NCAUSE_DEF  = 6;
  localparam int ADDR_W_DEF  = 2;
  localparam int ADDR_FLAG   = 0;
  localparam int ADDR_SHADOW = 1;
  localparam int ADDR_CLEAR  = 2;
  localparam int BIT_INT     = 0;
endpackage

// File: rtl/nmi_rst_sync.sv
module nmi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/nmi_cause_cell.sv
module nmi_cause_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o,
  output logic shadow_o
);
  logic flag_r, flag_d;
  logic shad_r, shad_d;
  logic en;

  always_comb begin
    en     = set_i | clr_i;
    flag_d = flag_r;
    shad_d = shad_r;
    if (clr_i) begin
      flag_d = 1'b0;
      shad_d = 1'b0;
    end
    if (set_i) begin
      flag_d = 1'b1;
      shad_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_r <= 1'b0;
      shad_r <= 1'b0;
    end else if (en) begin
      flag_r <= flag_d;
      shad_r <= shad_d;
    end
  end

  assign flag_o   = flag_r;
  assign shadow_o = shad_r;
endmodule

// File: rtl/nmi_int_ctrl.sv
module nmi_int_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic pending_i,
  input  logic arriving_i,
  input  logic clr_i,
  output logic int_o,
  output logic int_shadow_o,
  output logic pulse_o
);
  logic int_r, int_d;
  logic ishd_r, ishd_d;
  logic pulse_r;
  logic set_now;
  logic en;

  always_comb begin
    set_now = !int_r && (pending_i || arriving_i);
    en      = set_now | clr_i;
    int_d   = int_r;
    ishd_d  = ishd_r;
    if (clr_i) begin
      int_d  = 1'b0;
      ishd_d = 1'b0;
    end
    if (set_now) begin
      int_d  = 1'b1;
      ishd_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_r  <= 1'b0;
      ishd_r <= 1'b0;
    end else if (en) begin
      int_r  <= int_d;
      ishd_r <= ishd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_r <= 1'b0;
    else        pulse_r <= set_now;
  end

  assign int_o        = int_r;
  assign int_shadow_o = ishd_r;
  assign pulse_o      = pulse_r;
endmodule

// File: rtl/sticky_nmi_ctrl.sv
module sticky_nmi_ctrl
  import sticky_nmi_pkg::*;
#(
  parameter int REG_W  = REG_W_DEF,
  parameter int NCAUSE = NCAUSE_DEF,
  parameter int ADDR_W = ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCAUSE-1:0] cause_strb,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic [REG_W-1:0]  flag_q,
  output logic [REG_W-1:0]  shadow_q,
  output logic              nmi_pulse
);
  localparam int USED_W = NCAUSE + 1;

  logic              rst_sync_n;
  logic              clr_sel;
  logic [NCAUSE:0]   clr_mask;
  logic [NCAUSE-1:0] cause_flag;
  logic [NCAUSE-1:0] cause_shadow;
  logic              int_flag;
  logic              int_shadow;
  logic              unused_wdata_hi;

  nmi_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  assign clr_sel         = bus_wr && (bus_addr == ADDR_W'(ADDR_CLEAR));
  assign clr_mask        = clr_sel ? bus_wdata[NCAUSE:0] : '0;
  assign unused_wdata_hi = ^bus_wdata[REG_W-1:USED_W];

  for (genvar i = 0; i < NCAUSE; i++) begin : g_cause
    nmi_cause_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .set_i    (cause_strb[i]),
      .clr_i    (clr_mask[i+1]),
      .flag_o   (cause_flag[i]),
      .shadow_o (cause_shadow[i])
    );
  end

  nmi_int_ctrl u_int (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .pending_i    (|cause_flag),
    .arriving_i   (|cause_strb),
    .clr_i        (clr_mask[BIT_INT]),
    .int_o        (int_flag),
    .int_shadow_o (int_shadow),
    .pulse_o      (nmi_pulse)
  );

  assign flag_q   = {{(REG_W-USED_W){1'b0}}, cause_flag, int_flag};
  assign shadow_q = {{(REG_W-USED_W){1'b0}}, cause_shadow, int_shadow};

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(ADDR_FLAG))   bus_rdata = flag_q;
    if (bus_addr == ADDR_W'(ADDR_SHADOW)) bus_rdata = shadow_q;
  end
endmodule

// File: rtl/sticky_nmi_ctrl_chk.sv
module sticky_nmi_ctrl_chk
  import sticky_nmi_pkg::*;
#(
  parameter int REG_W  = REG_W_DEF,
  parameter int NCAUSE = NCAUSE_DEF,
  parameter int ADDR_W = ADDR_W_DEF
) (
  input logic              clk,
  input logic              rst_ok,
  input logic [NCAUSE-1:0] cause_strb,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [REG_W-1:0]  bus_wdata,
  input logic [REG_W-1:0]  bus_rdata,
  input logic [REG_W-1:0]  flag_q,
  input logic [REG_W-1:0]  shadow_q,
  input logic              nmi_pulse
);
  logic [NCAUSE:0] wr_clr;
  logic            unused_chk;
  assign wr_clr = (bus_wr && bus_addr == ADDR_W'(ADDR_CLEAR)) ? bus_wdata[NCAUSE:0] : '0;
  assign unused_chk = ^bus_wdata;

  assert_cause_set_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (|cause_strb) |=> ((flag_q[NCAUSE:1] & $past(cause_strb)) == $past(cause_strb)));

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    ((($past(flag_q[NCAUSE:1]) & ~flag_q[NCAUSE:1]) & ~$past(wr_clr[NCAUSE:1])) == '0));

  assert_shadow_mirror_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    shadow_q == flag_q);

  assert_pulse_width_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    nmi_pulse |=> !nmi_pulse);

  assert_pulse_edge_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    nmi_pulse |-> (flag_q[BIT_INT] && !$past(flag_q[BIT_INT])));

  assert_no_repulse_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(flag_q[BIT_INT]) && flag_q[BIT_INT]) |-> !nmi_pulse);

  assert_rearm_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (!flag_q[BIT_INT] && (|flag_q[NCAUSE:1])) |=> (flag_q[BIT_INT] && nmi_pulse));

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    (flag_q[REG_W-1:NCAUSE+1] == '0) && (shadow_q[REG_W-1:NCAUSE+1] == '0));

  assert_clear_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    (bus_addr == ADDR_W'(ADDR_CLEAR)) |-> (bus_rdata == '0));
endmodule

bind sticky_nmi_ctrl sticky_nmi_ctrl_chk #(
  .REG_W(REG_W), .NCAUSE(NCAUSE), .ADDR_W(ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_ok     (rst_sync_n),
  .cause_strb (cause_strb),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .flag_q     (flag_q),
  .shadow_q   (shadow_q),
  .nmi_pulse  (nmi_pulse)
);

// File: tb/sticky_nmi_ctrl_test.sv
`timescale 1ns/1ps
module sticky_nmi_ctrl_test;
  logic        clk;
  logic        rst_n;
  logic [5:0]  cause_strb;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [15:0] flag_q;
  logic [15:0] shadow_q;
  logic        nmi_pulse;

  int nchk = 0;
  int nerr = 0;
  logic [15:0] m_flag;
  logic        m_nmi;

  sticky_nmi_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cause_strb(cause_strb), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .flag_q(flag_q), .shadow_q(shadow_q), .nmi_pulse(nmi_pulse)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [16:0] mdl_step(input logic [15:0] f, input logic [5:0] s,
                                           input logic wr, input logic [1:0] a,
                                           input logic [15:0] d);
    logic [15:0] clr;
    logic [5:0]  causes;
    logic        iset, inext;
    clr    = (wr && a == 2'd2) ? d : 16'h0;
    causes = s | (f[6:1] & ~clr[6:1]);
    iset   = !f[0] && ((|f[6:1]) || (|s));
    inext  = iset | (f[0] & ~clr[0]);
    return {iset, 9'b0, causes, inext};
  endfunction

  function automatic logic [15:0] mdl_read(input logic [15:0] f, input logic [1:0] a);
    return (a == 2'd0 || a == 2'd1) ? f : 16'h0;
  endfunction

  task automatic chk(input string tag, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [5:0] s, input logic wr, input logic [1:0] a,
                      input logic [15:0] d, input string tag);
    logic [16:0] nx;
    cause_strb = s; bus_wr = wr; bus_addr = a; bus_wdata = d;
    nx = mdl_step(m_flag, s, wr, a, d);
    @(posedge clk);
    @(negedge clk);
    m_nmi  = nx[16];
    m_flag = nx[15:0];
    chk(tag, "flag", flag_q, m_flag);
    chk("R4", "shadow", shadow_q, m_flag);
    chk(tag, "nmi", {15'b0, nmi_pulse}, {15'b0, m_nmi});
    chk("R9", "rdata", bus_rdata, mdl_read(m_flag, a));
  endtask

  initial begin
    #(8 * 200000);
    nerr++;
    $display("FAIL watchdog all act=timeout exp=finished");
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    rst_n = 1'b0; cause_strb = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    m_flag = '0; m_nmi = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "flag", flag_q, 16'h0);
    chk("R1", "shadow", shadow_q, 16'h0);
    chk("R1", "nmi", {15'b0, nmi_pulse}, 16'h0);

    // R2: clock-fail strobe sets bit 1 and the interrupt flag, with a pulse
    step(6'b000001, 1'b0, 2'd0, 16'h0, "R2");
    chk("R2", "flag value", flag_q, 16'h0003);
    chk("R6", "pulse", {15'b0, nmi_pulse}, 16'h0001);
    step(6'b000000, 1'b0, 2'd1, 16'h0, "R6");
    chk("R6", "pulse dropped", {15'b0, nmi_pulse}, 16'h0000);
    // R7: another cause while the interrupt flag is set gives no pulse
    step(6'b000010, 1'b0, 2'd0, 16'h0, "R7");
    chk("R7", "no pulse", {15'b0, nmi_pulse}, 16'h0000);
    chk("R7", "flag value", flag_q, 16'h0007);
    // R3: zero clear, writes to flag and shadow addresses are ignored
    step(6'b000000, 1'b1, 2'd2, 16'h0000, "R3");
    step(6'b000000, 1'b1, 2'd0, 16'hFFFF, "R3");
    step(6'b000000, 1'b1, 2'd1, 16'hFFFF, "R3");
    chk("R3", "flag held", flag_q, 16'h0007);
    // R5: set beats clear on bit 2
    step(6'b000010, 1'b1, 2'd2, 16'h0004, "R5");
    chk("R5", "bit2 set", flag_q, 16'h0007);
    // R4: clear causes
    step(6'b000000, 1'b1, 2'd2, 16'h0006, "R4");
    chk("R4", "flag cleared", flag_q, 16'h0001);
    chk("R4", "shadow cleared", shadow_q, 16'h0001);
    chk("R9", "clear reads 0", bus_rdata, 16'h0000);
    // R8: clearing the interrupt with no cause gives no new pulse
    step(6'b000000, 1'b1, 2'd2, 16'h0001, "R8");
    step(6'b000000, 1'b0, 2'd3, 16'h0, "R8");
    chk("R8", "no rearm", flag_q, 16'h0000);
    // R8: pending cause re-arms after the interrupt flag is cleared
    step(6'b000100, 1'b0, 2'd0, 16'h0, "R2");
    chk("R2", "flash bit", flag_q, 16'h0009);
    step(6'b000000, 1'b1, 2'd2, 16'h0001, "R8");
    chk("R8", "int cleared", flag_q, 16'h0008);
    step(6'b000000, 1'b0, 2'd0, 16'h0, "R8");
    chk("R8", "rearmed", flag_q, 16'h0009);
    chk("R8", "new pulse", {15'b0, nmi_pulse}, 16'h0001);
    step(6'b000000, 1'b1, 2'd2, 16'hFFFF, "R4");
    step(6'b000000, 1'b0, 2'd0, 16'h0, "R4");
    chk("R4", "all clear", flag_q, 16'h0000);

    // random traffic
    for (int n = 0; n < 600; n++) begin
      logic [5:0]  s;
      logic        wr;
      logic [1:0]  a;
      logic [15:0] d;
      for (int b = 0; b < 6; b++) s[b] = ($urandom % 12) == 0;
      wr = ($urandom % 3) == 0;
      a  = 2'($urandom % 4);
      if (wr && ($urandom % 2) == 0) a = 2'd2;
      d  = 16'($urandom);
      step(s, wr, a, d, "R3");
    end

    cause_strb = '0; bus_wr = 1'b0;
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule